// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, one destination address at a time, whether an incoming Ethernet frame is kept. The receive path presents the 48-bit destination address together with a one-cycle strobe. Registered accept or reject pulses come back one cycle later. The address is first compared in parallel against sixteen programmable station entries. If none of them matches, a 12-bit hash taken from the two last address bytes selects one bit of a 4096-bit group table. That bit decides the outcome.

Software programs the station entries and the group table through a simple word-wide write port. Accepts that come from the group table are tallied in a saturating counter. The lookup side carries no back-pressure: there is no ready signal, one address may be presented on every cycle, and the block never stalls. Each strobe produces exactly one result pulse, one cycle later.

Top module: `rx_addr_filter`

## Requirements
- R1: Reset clears every station valid flag, every group-table bit and the hit counter, so any lookup after reset is rejected and `mc_hit_count` reads 0.
- R2: Address byte k is `da[8k+7:8k]`. Station entry i is written at `cfg_addr` 2i (low word = bytes 3..0, byte 0 in bits 7:0) and 2i+1 (bits 15:0 = bytes 5..4, bit 31 = valid flag). Any of the sixteen entries that is valid and equal to `da` gives an accept.
- R3: An entry whose valid flag is clear never matches, even when its stored address equals `da`.
- R4: A station match accepts the frame no matter what the group table holds, and it does not change `mc_hit_count`.
- R5: The hash input is {byte5, byte4} = `da[47:32]`. It is shifted right by 4, 3, 2 or 0 for `hash_mode` 0, 1, 2 and 3, and the low 12 bits are kept. The hash does not affect the station compare.
- R6: Group-table word w (0..127) is written at `cfg_addr` 256+w. Hash bits 11:5 pick the word and bits 4:0 pick the bit. A set bit accepts a frame that matched no station entry, and a clear bit rejects it.
- R7: Each accept that comes from the group table adds one to `mc_hit_count`. Once the counter reaches its all-ones value it stays there.
- R8: `frame_accept` or `frame_reject`, exactly one of them, is high for one cycle on the cycle after a `da_valid` cycle. Both are low otherwise.
- R9: A configuration write and a lookup in the same cycle: the lookup uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 9 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| hash_mode | input | 2 | Selects the hash bit window |
| da_valid | input | 1 | Destination address strobe, one lookup per cycle |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_accept | output | 1 | One-cycle accept pulse |
| frame_reject | output | 1 | One-cycle reject pulse |
| mc_hit_count | output | CNT_W | Saturating count of group-table accepts |

## Verification
Any wrong internal state shows up at the result pulses on the cycle right after the strobe that reads it. A stuck or dropped valid flag, or a misplaced byte lane, flips the outcome of a station lookup. A wrong hash window or table index flips the outcome for one mode while the other modes stay correct. A counter fault shows up in the same cycle as the result pulse: it either moves on a station hit or wraps from all-ones. A same-cycle write that leaks through changes the very result that the write should not yet affect.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned MAC_W     = 48;
  localparam int unsigned HASH_W    = 12;
  localparam int unsigned TBL_WW    = 32;
  localparam int unsigned BIT_SEL_W = $clog2(TBL_WW);
  localparam int unsigned TBL_WORDS = (1 << HASH_W) / TBL_WW;
  localparam int unsigned WORD_SEL_W = HASH_W - BIT_SEL_W;
  localparam int unsigned CFG_AW    = $clog2(TBL_WORDS) + 2;
  localparam int unsigned TBL_BASE  = 1 << (CFG_AW - 1);
  localparam int unsigned VALID_BIT = 31;

  typedef enum logic [1:0] {
    HWIN_SHR4 = 2'd0,
    HWIN_SHR3 = 2'd1,
    HWIN_SHR2 = 2'd2,
    HWIN_SHR0 = 2'd3
  } hash_win_e;

  function automatic logic [HASH_W-1:0] hash_of(input logic [15:0] top16,
                                                 input logic [1:0]  mode);
    logic [15:0] s;
    case (hash_win_e'(mode))
      HWIN_SHR4: s = top16 >> 4;
      HWIN_SHR3: s = top16 >> 3;
      HWIN_SHR2: s = top16 >> 2;
      default:   s = top16;
    endcase
    return s[HASH_W-1:0];
  endfunction
endpackage

// File: rtl/rxf_station_bank.sv
module rxf_station_bank #(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned AW    = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [31:0]              wdata,
  input  logic [rxf_pkg::MAC_W-1:0] da,
  output logic                     any_hit
);
  import rxf_pkg::*;

  logic [N_ENT-1:0] hit;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam logic [AW-1:0] LO_A = AW'(2 * i);
    localparam logic [AW-1:0] HI_A = AW'(2 * i + 1);
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else if (we && waddr == LO_A) begin
        lo_q <= wdata;
      end else if (we && waddr == HI_A) begin
        hi_q  <= wdata[15:0];
        vld_q <= wdata[VALID_BIT];
      end
    end

    assign hit[i] = vld_q && ({hi_q, lo_q} == da);

    // R3: a clear valid flag right after its write must not give a match
    AST_CLEARED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == HI_A && !wdata[VALID_BIT]) |=> !hit[i]); // R3
  end

  assign any_hit = |hit;
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int unsigned AW = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [31:0]                wdata,
  input  logic [rxf_pkg::HASH_W-1:0] hidx,
  output logic                       bit_set
);
  import rxf_pkg::*;

  logic [TBL_WW-1:0] mem_q [TBL_WORDS];
  logic              sel;
  logic [AW-1:0]     woff;

  assign woff = waddr - AW'(TBL_BASE);
  assign sel  = we && (waddr >= AW'(TBL_BASE)) && (woff < AW'(TBL_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < int'(TBL_WORDS); w++) mem_q[w] <= '0;
    end else if (sel) begin
      mem_q[woff[WORD_SEL_W-1:0]] <= wdata[TBL_WW-1:0];
    end
  end

  assign bit_set = mem_q[hidx[HASH_W-1:BIT_SEL_W]][hidx[BIT_SEL_W-1:0]];
endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP) |=> (cnt == TOP)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt)); // R7
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int unsigned N_STATION = 16,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [rxf_pkg::CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  input  logic [1:0]                  hash_mode,
  input  logic                        da_valid,
  input  logic [rxf_pkg::MAC_W-1:0]   da,
  output logic                        frame_accept,
  output logic                        frame_reject,
  output logic [CNT_W-1:0]            mc_hit_count
);
  import rxf_pkg::*;

  logic              exact_hit;
  logic              tbl_bit;
  logic [HASH_W-1:0] hidx;
  logic              keep;
  logic              mc_inc;

  rxf_station_bank #(.N_ENT(N_STATION), .AW(CFG_AW)) u_station (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .da(da), .any_hit(exact_hit)
  );

  assign hidx = hash_of(da[47:32], hash_mode);

  rxf_hash_table #(.AW(CFG_AW)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .hidx(hidx), .bit_set(tbl_bit)
  );

  assign keep   = exact_hit || tbl_bit;
  assign mc_inc = da_valid && !exact_hit && tbl_bit;

  rxf_sat_counter #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(mc_inc), .cnt(mc_hit_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_accept <= 1'b0;
      frame_reject <= 1'b0;
    end else begin
      frame_accept <= da_valid && keep;
      frame_reject <= da_valid && !keep;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> (frame_accept != frame_reject)); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> (!frame_accept && !frame_reject)); // R8
  AST_STATION_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && exact_hit) |=> frame_accept); // R4
  AST_STATION_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && exact_hit) |=> (mc_hit_count == $past(mc_hit_count))); // R4
  AST_REJECT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_reject |-> (mc_hit_count == $past(mc_hit_count))); // R7
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [8:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [1:0]    hash_mode = '0;
  logic          da_valid = 1'b0;
  logic [47:0]   da = '0;
  logic          frame_accept, frame_reject;
  logic [CW-1:0] mc_hit_count;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_addr_filter #(.N_STATION(16), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hash_mode(hash_mode), .da_valid(da_valid),
    .da(da), .frame_accept(frame_accept), .frame_reject(frame_reject),
    .mc_hit_count(mc_hit_count)
  );

  localparam logic [47:0] ADDR_X  = 48'h47A5_0000_00F0;
  localparam logic [47:0] ADDR_E3 = 48'h0605_0403_0201;
  localparam logic [47:0] ADDR_EF = 48'hABCD_1234_5678;
  localparam logic [47:0] ADDR_E5 = 48'h1111_2222_3333;
  localparam logic [47:0] ADDR_E7 = 48'h47A5_0000_0001;
  localparam logic [47:0] ADDR_Y  = 48'h9999_8888_7777;

  // {mode[51:50], addr[49:2], expect_accept[1], expect_count_step[0]}
  localparam int NV = 10;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, ADDR_X,            1'b1, 1'b1},  // R5 R6 window >>4 -> word 35 bit 26
    {2'd1, ADDR_X,            1'b0, 1'b0},  // R5 window >>3 -> word 71 bit 20
    {2'd2, ADDR_X,            1'b0, 1'b0},  // R5 window >>2 -> word 15 bit 9
    {2'd3, ADDR_X,            1'b1, 1'b1},  // R5 R6 no shift -> word 61 bit 5
    {2'd0, ADDR_E3,           1'b1, 1'b0},  // R2 station entry 3
    {2'd2, ADDR_EF,           1'b1, 1'b0},  // R2 station entry 15
    {2'd0, ADDR_E5,           1'b0, 1'b0},  // R3 invalid entry 5
    {2'd0, ADDR_E7,           1'b1, 1'b0},  // R4 station beats table
    {2'd1, 48'h0605_0403_0200, 1'b0, 1'b0}, // R2 one bit off entry 3
    {2'd3, 48'h0,             1'b0, 1'b0}   // R6 clear table bit
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [1:0] m, input logic [47:0] a);
    @(negedge clk);
    da_valid = 1'b1; hash_mode = m; da = a;
    @(negedge clk);
    da_valid = 1'b0;
  endtask

  task automatic station(input int idx, input logic [47:0] a, input logic v);
    wr(9'(2 * idx), a[31:0]);
    wr(9'(2 * idx + 1), {v, 15'd0, a[47:32]});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [CW-1:0] exp_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R8: quiet outputs and empty counter after reset
    chk("R8 idle accept", frame_accept, 0);
    chk("R8 idle reject", frame_reject, 0);
    chk("R1 count", mc_hit_count, 0);
    look(2'd0, ADDR_X);
    chk("R1 reject after reset", {frame_accept, frame_reject}, 2'b01);

    station(3, ADDR_E3, 1'b1);
    station(15, ADDR_EF, 1'b1);
    station(5, ADDR_E5, 1'b0);
    station(7, ADDR_E7, 1'b1);
    wr(9'd256 + 9'd35, 32'h1 << 26);
    wr(9'd256 + 9'd61, 32'h1 << 5);

    exp_cnt = '0;
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][51:50], VEC[i][49:2]);
      if (VEC[i][0]) exp_cnt = exp_cnt + 1'b1;
      chk($sformatf("R2-R6 vector %0d result", i), {frame_accept, frame_reject},
          {VEC[i][1], !VEC[i][1]});
      chk($sformatf("R4 R7 vector %0d count", i), mc_hit_count, exp_cnt);
    end
    @(negedge clk);
    chk("R8 pulse ends", {frame_accept, frame_reject}, 2'b00);

    // R9: write and lookup in the same cycle use old contents
    wr(9'd18, ADDR_Y[31:0]);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 9'd19; cfg_wdata = {1'b1, 15'd0, ADDR_Y[47:32]};
    da_valid = 1'b1; hash_mode = 2'd1; da = ADDR_Y;
    @(negedge clk);
    cfg_we = 1'b0; da_valid = 1'b0;
    chk("R9 set valid same cycle", {frame_accept, frame_reject}, 2'b01);
    look(2'd1, ADDR_Y);
    chk("R9 set valid next cycle", {frame_accept, frame_reject}, 2'b10);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 9'd19; cfg_wdata = {1'b0, 15'd0, ADDR_Y[47:32]};
    da_valid = 1'b1; da = ADDR_Y;
    @(negedge clk);
    cfg_we = 1'b0; da_valid = 1'b0;
    chk("R9 clear valid same cycle", {frame_accept, frame_reject}, 2'b10);
    look(2'd1, ADDR_Y);
    chk("R3 cleared entry", {frame_accept, frame_reject}, 2'b01);

    // R7: saturation at all-ones
    for (int k = 0; k < 7; k++) begin
      look(2'd0, ADDR_X);
      if (exp_cnt != '1) exp_cnt = exp_cnt + 1'b1;
      chk("R7 saturating count", mc_hit_count, exp_cnt);
    end

    // R1: second reset wipes stations, table and counter
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 count cleared", mc_hit_count, 0);
    look(2'd0, ADDR_E3);
    chk("R1 station cleared", {frame_accept, frame_reject}, 2'b01);
    look(2'd3, ADDR_X);
    chk("R1 table cleared", {frame_accept, frame_reject}, 2'b01);
    finish_run();
  end
endmodule